// File: doc/BRIEF.md
# Pin Capture Unit

The pin capture unit timestamps events on an asynchronous input pin. It watches the pin through a synchronizer and, when the selected transition arrives, copies the value of an external free-running counter into a capture register and raises a sticky capture flag. Software or a neighbouring block reads the captured value to measure pulse widths and periods. It clears the flag by writing a one to the clear input.

An optional noise canceller sits between the synchronizer and the edge detector. When it is enabled, the pin must show the same new level on four consecutive samples before a transition counts. Glitches shorter than that are dropped. The canceller adds a fixed four clocks to the capture path, so the captured count is always offset from the true pin transition by a known constant.

Top module: `pin_capture_unit`

## Requirements
- R1: On a qualified edge the capture register loads the counter value present at the capturing clock edge, and at all other times it holds its value.
- R2: With `edge_rise_i` = 1 only a low-to-high pin transition is captured; with `edge_rise_i` = 0 only a high-to-low transition is captured. The opposite transition leaves the capture register unchanged.
- R3: The pin passes through a two-flop synchronizer. With the canceller off, capture happens at the second clock edge after the first edge that samples the new pin level, and the register holds the counter value present at that edge.
- R4: With `filt_en_i` = 1 a new level is accepted only after four consecutive synchronized samples agree on it.
- R5: Enabling the canceller delays capture by exactly four more clock edges than with it off (the sixth edge after the first sampling edge).
- R6: With the canceller on, a pin pulse lasting fewer than four samples causes no capture. With it off, a single-sample pulse is captured.
- R7: `cap_flag_o` goes to 1 at the same clock edge that loads the capture register.
- R8: A one on `flag_clr_i` clears the flag at the next edge, unless a capture happens at that same edge, in which case the flag stays 1.
- R9: A capture while the flag is already 1 overwrites the capture register and leaves the flag at 1.
- R10: After reset the capture register is 0, the flag is 0 and the pin level is taken as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| cnt_i | input | CNT_W | Value of the free-running counter |
| edge_rise_i | input | 1 | 1 = capture on rising edge, 0 = capture on falling edge |
| filt_en_i | input | 1 | 1 = noise canceller enabled |
| flag_clr_i | input | 1 | Write-one pulse that clears the capture flag |
| cap_val_o | output | CNT_W | Capture register |
| cap_flag_o | output | 1 | Capture flag |

## Verification
With the canceller off, the flag and register change at the second clock edge after the first edge that samples the new pin level. With it on, they change at the sixth. The bench drives the pin on a falling clock edge and records the counter there. It then expects the flag to still be low one cycle before the due edge, and expects the flag high with the counter value plus the latency right after that edge. For a falling-edge capture the reference point is the cycle in which the pin is released, not when it was raised. Short pulses get a long quiet window afterwards to show that nothing changes. Flag clearing uses single-cycle pulses timed against the known capture edge, including the cycle in which a clear and a capture coincide.

// File: rtl/capunit_pkg.sv
package capunit_pkg;

   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_pol_e;

   localparam int unsigned DEF_CNT_W       = 16;
   localparam int unsigned DEF_SYNC_STAGES = 2;
   localparam int unsigned DEF_FILT_LEN    = 4;

endpackage

// File: rtl/capunit_sync.sv
module capunit_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic sync_o
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[0] <= 1'b0;
      else         chain_q[0] <= async_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q[s] <= 1'b0;
         else         chain_q[s] <= chain_q[s-1];
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/capunit_filter.sv
module capunit_filter #(
   parameter int unsigned FILT_LEN = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic smp_i,
   input  logic lvl_prev_i,
   output logic lvl_o
);

   logic [FILT_LEN-1:0] hist_q;
   logic                all_hi;
   logic                all_lo;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q[0] <= 1'b0;
      else         hist_q[0] <= smp_i;
   end

   for (genvar i = 1; i < FILT_LEN; i++) begin : g_hist
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) hist_q[i] <= 1'b0;
         else         hist_q[i] <= hist_q[i-1];
      end
   end

   assign all_hi = &hist_q;
   assign all_lo = ~|hist_q;

   always_comb begin
      if (!en_i)       lvl_o = smp_i;
      else if (all_hi) lvl_o = 1'b1;
      else if (all_lo) lvl_o = 1'b0;
      else             lvl_o = lvl_prev_i;
   end

endmodule

// File: rtl/capunit_edge.sv
module capunit_edge
   import capunit_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      lvl_i,
   input  edge_pol_e pol_i,
   output logic      lvl_q_o,
   output logic      hit_o
);

   logic lvl_q;
   logic rise;
   logic fall;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q <= 1'b0;
      else         lvl_q <= lvl_i;
   end

   assign rise    = lvl_i & ~lvl_q;
   assign fall    = ~lvl_i & lvl_q;
   assign hit_o   = (pol_i == EDGE_RISE) ? rise : fall;
   assign lvl_q_o = lvl_q;

endmodule

// File: rtl/pin_capture_unit.sv
module pin_capture_unit
   import capunit_pkg::*;
#(
   parameter int unsigned CNT_W       = DEF_CNT_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
   parameter int unsigned FILT_LEN    = DEF_FILT_LEN
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cap_pin_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             edge_rise_i,
   input  logic             filt_en_i,
   input  logic             flag_clr_i,
   output logic [CNT_W-1:0] cap_val_o,
   output logic             cap_flag_o
);

   if (CNT_W < 2) begin : g_bad_width
      $error("pin_capture_unit: CNT_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pin_capture_unit: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 2) begin : g_bad_filt
      $error("pin_capture_unit: FILT_LEN must be at least 2");
   end

   logic             pin_sync;
   logic             lvl;
   logic             lvl_q;
   logic             hit;
   logic [CNT_W-1:0] cap_q;
   logic             flag_q;

   capunit_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (cap_pin_i),
      .sync_o  (pin_sync)
   );

   capunit_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (filt_en_i),
      .smp_i      (pin_sync),
      .lvl_prev_i (lvl_q),
      .lvl_o      (lvl)
   );

   capunit_edge u_edge (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lvl_i   (lvl),
      .pol_i   (edge_pol_e'(edge_rise_i)),
      .lvl_q_o (lvl_q),
      .hit_o   (hit)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cap_q <= '0;
      else if (hit) cap_q <= cnt_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flag_q <= 1'b0;
      else if (hit)        flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
   end

   assign cap_val_o  = cap_q;
   assign cap_flag_o = flag_q;

endmodule

// File: rtl/pin_capture_chk.sv
module pin_capture_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             hit_i,
   input logic             sel_i,
   input logic             lvl_q_i,
   input logic [CNT_W-1:0] cnt_i,
   input logic [CNT_W-1:0] cap_i,
   input logic             flag_i,
   input logic             clr_i
);

   // R1
   cap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i |=> cap_i == $past(cnt_i));

   // R1
   cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit_i |=> $stable(cap_i));

   // R2
   edge_pol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i |=> lvl_q_i == $past(sel_i));

   // R7
   flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i |=> flag_i);

   // R8
   flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !hit_i) |=> !flag_i);

   // R9
   flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !hit_i) |=> $stable(flag_i));

endmodule

bind pin_capture_unit pin_capture_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .hit_i   (hit),
   .sel_i   (edge_rise_i),
   .lvl_q_i (lvl_q),
   .cnt_i   (cnt_i),
   .cap_i   (cap_val_o),
   .flag_i  (cap_flag_o),
   .clr_i   (flag_clr_i)
);

// File: tb/sim_pin_capture_unit.sv
module sim_pin_capture_unit;

   localparam int CLK_PERIOD = 10;
   localparam int CW         = 16;
   localparam int N_VEC      = 10;
   // {sel, filt, expect, len[4:0]}
   localparam logic [7:0] VEC [N_VEC] = '{
      {1'b1, 1'b0, 1'b1, 5'd10},
      {1'b0, 1'b0, 1'b1, 5'd10},
      {1'b1, 1'b0, 1'b1, 5'd1},
      {1'b0, 1'b0, 1'b1, 5'd1},
      {1'b1, 1'b1, 1'b1, 5'd10},
      {1'b0, 1'b1, 1'b1, 5'd10},
      {1'b1, 1'b1, 1'b1, 5'd4},
      {1'b1, 1'b1, 1'b0, 5'd3},
      {1'b0, 1'b1, 1'b0, 5'd3},
      {1'b0, 1'b1, 1'b1, 5'd4}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pin = 1'b0;
   logic [CW-1:0] cnt = '0;
   logic          sel = 1'b1;
   logic          filt = 1'b0;
   logic          clr = 1'b0;
   logic [CW-1:0] cap;
   logic          flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cnt <= cnt + 1'b1;

   pin_capture_unit u0 (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .cap_pin_i   (pin),
      .cnt_i       (cnt),
      .edge_rise_i (sel),
      .filt_en_i   (filt),
      .flag_clr_i  (clr),
      .cap_val_o   (cap),
      .cap_flag_o  (flag)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_flag();
      @(negedge clk) clr = 1'b1;
      @(negedge clk) clr = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [CW-1:0] cref;
      logic [CW-1:0] prev;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(flag == 1'b0, "R10 flag after reset", flag, 0);
      chk(cap == '0, "R10 cap after reset", cap, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 R2 R3 R4 R5 R6 R7: table walk
      for (int v = 0; v < N_VEC; v++) begin
         bit sv, fv, ev;
         int len, lat, rt;
         {sv, fv, ev} = VEC[v][7:5];
         len  = int'(VEC[v][4:0]);
         lat  = fv ? 6 : 2;
         rt   = sv ? 0 : len;
         sel  = sv;
         filt = fv;
         pin  = 1'b0;
         repeat (10) @(negedge clk);
         clear_flag();
         prev = cap;
         cref = cnt;
         pin  = 1'b1;
         for (int t = 1; t <= 40; t++) begin
            @(negedge clk);
            if (ev && t == rt + lat)
               chk(flag == 1'b0, "R3/R5 flag before due edge", flag, 0);
            if (ev && t == rt + lat + 1) begin
               chk(flag == 1'b1, "R7 flag at due edge", flag, 1);
               chk(cap == cref + CW'(lat), "R1 captured value", cap, cref + CW'(lat));
            end
            if (t == len) begin
               if (!sv) cref = cnt;
               pin = 1'b0;
            end
         end
         if (ev)
            chk(cap == cref + CW'(lat), "R2 opposite edge ignored", cap, cref + CW'(lat));
         else begin
            chk(flag == 1'b0, "R6 short pulse flag", flag, 0);
            chk(cap == prev, "R4 short pulse cap", cap, prev);
         end
      end

      // R8: write-one clear
      chk(flag == 1'b1, "R8 flag set before clear", flag, 1);
      clear_flag();
      chk(flag == 1'b0, "R8 flag cleared", flag, 0);

      // R9: overwrite while flag set
      sel  = 1'b1;
      filt = 1'b0;
      pin  = 1'b1;
      repeat (3) @(negedge clk);
      pin = 1'b0;
      repeat (10) @(negedge clk);
      chk(flag == 1'b1, "R9 first capture flag", flag, 1);
      cref = cnt;
      pin  = 1'b1;
      repeat (3) @(negedge clk);
      pin = 1'b0;
      repeat (10) @(negedge clk);
      chk(flag == 1'b1, "R9 flag stays set", flag, 1);
      chk(cap == cref + CW'(2), "R9 register overwritten", cap, cref + CW'(2));

      // R8: clear coinciding with capture, capture wins
      clear_flag();
      chk(flag == 1'b0, "R8 flag clear before collision", flag, 0);
      cref = cnt;
      pin  = 1'b1;
      @(negedge clk);
      @(negedge clk) clr = 1'b1;
      @(negedge clk) clr = 1'b0;
      chk(flag == 1'b1, "R8 set wins over clear", flag, 1);
      chk(cap == cref + CW'(2), "R8 collision capture value", cap, cref + CW'(2));
      pin = 1'b0;
      repeat (5) @(negedge clk);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule